// File: doc/BRIEF.md
# Host Port Interrupt Request Unit

This block sits on the host side of a byte-wide parallel port between a host processor and a DSP. It keeps a transmit-empty flag, a receive-full flag and two request-enable bits. From these it forms an active-low interrupt request that several devices can share on one wired-OR line. The host sees a small register file: control, command, status, vector and data. The host addresses it with a 3-bit address, an active-low strobe and a read/write line.

When the host acknowledges a pending request, the block puts its vector byte on the data bus in place of register data. The host can then branch to the right service routine. The host also issues commands to the DSP by setting a command bit. That bit stays set until the DSP side accepts the command. The host can therefore poll the bit to learn when the command has been taken.

Top module: `host_irq_unit`

Register map. Address 0 is control: bit0 is the receive enable, bit1 is the transmit enable, and bits 6:5 are the mode. Address 1 is command: bit7 is the command bit and bits 4:0 are the command code. Address 2 is status and is read-only: bit0 is receive-full, bit1 is transmit-empty, bit6 is DMA-active and bit7 is request. Address 3 is the vector register. Address 6 is data: a write goes to the transmit byte and a read returns the received byte. Every other address reads as 0.

## Requirements
- R1: After reset, status reads 0x02 (transmit-empty set, all else clear), the vector reads 0x0F, control and command read 0x00, and the request line is released.
- R2: The request (`irq_pull_low`=1) is active only when the mode field is 0 and (transmit-empty AND transmit enable) OR (receive-full AND receive enable) holds. Any non-zero mode suppresses it.
- R3: The request releases on the clock after the enabled condition clears. The condition clears when the host writes the data register, reads the data register, or clears the enable bit.
- R4: While the request is active and `h_ack_n` is low, `h_dout` carries the vector register and `h_dout_oe` is 1. This takes priority over any register read. When acknowledge is given with no request pending, nothing is driven unless a read is in progress.
- R5: Status bit7 always equals the request output. Status bit6 is 1 whenever the mode field is non-zero.
- R6: A host write to address 1 with bit7=1 sets `cmd_pending` on the next clock and stores bits 4:0 in `cmd_code`. The host cannot clear the bit. A one-cycle `cmd_accept` clears it on the next clock. A host set in the same cycle as accept is ignored.
- R7: A host write to the data address clears transmit-empty and stores the byte on `tx_byte`. A `dsp_tx_taken` pulse sets transmit-empty.
- R8: A `dsp_rx_load` pulse sets receive-full and captures `dsp_rx_data`. A host read of the data address clears receive-full, unless a load happens in the same cycle.
- R9: An access takes effect once per strobe, on the first clock with `h_strobe_n` low. Holding the strobe low does not repeat it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_addr | input | 3 | Host register address |
| h_strobe_n | input | 1 | Active-low host access strobe |
| h_rnw | input | 1 | 1 = read, 0 = write |
| h_din | input | 8 | Host write data |
| h_ack_n | input | 1 | Active-low interrupt acknowledge |
| h_dout | output | 8 | Host read data or vector |
| h_dout_oe | output | 1 | Data bus drive enable |
| irq_pull_low | output | 1 | Open-drain enable; 1 pulls the request line low |
| dsp_tx_taken | input | 1 | DSP took the transmit byte |
| dsp_rx_load | input | 1 | DSP loads a receive byte |
| dsp_rx_data | input | 8 | Receive byte from DSP |
| tx_byte | output | 8 | Transmit byte for DSP |
| cmd_pending | output | 1 | Host command bit |
| cmd_code | output | 5 | Host command code |
| cmd_accept | input | 1 | DSP accepts the command (one cycle) |

## Verification
The bench first walks a table of combinations of mode, enables and flags through the request output and the status register. A design that ignored the mode, or swapped an enable, would raise or drop the request in the wrong rows. It then holds the strobe low while a new receive byte arrives. A level-triggered design would clear receive-full a second time and lose the byte. It also collides a host command write with a DSP accept, and tries to clear the command bit from the host side. A wrong priority would leave the command pending forever. Finally it acknowledges with and without a pending request during a status read. A design without vector priority returns status, and one without the request qualifier drives the vector when it should not.

// File: rtl/host_irq_unit.sv
module host_irq_unit #(
  parameter logic [7:0] VEC_RESET = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] h_addr,
  input  logic       h_strobe_n,
  input  logic       h_rnw,
  input  logic [7:0] h_din,
  input  logic       h_ack_n,
  output logic [7:0] h_dout,
  output logic       h_dout_oe,
  output logic       irq_pull_low,
  input  logic       dsp_tx_taken,
  input  logic       dsp_rx_load,
  input  logic [7:0] dsp_rx_data,
  output logic [7:0] tx_byte,
  output logic       cmd_pending,
  output logic [4:0] cmd_code,
  input  logic       cmd_accept
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_VEC  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd6;

  logic       strobe_q, rx_en, tx_en, cmd_q, txe, rxf;
  logic [1:0] mode;
  logic [4:0] cmd_code_q;
  logic [7:0] vec_q, rx_q, tx_q, reg_rd;

  wire access = strobe_q & ~h_strobe_n;
  wire wr     = access & ~h_rnw;
  wire rd     = access & h_rnw;
  wire dma_on = |mode;
  wire req    = ~dma_on & ((txe & tx_en) | (rxf & rx_en));
  wire vec_go = req & ~h_ack_n;

  always_comb begin
    case (h_addr)
      A_CTRL:  reg_rd = {1'b0, mode, 3'b000, tx_en, rx_en};
      A_CMD:   reg_rd = {cmd_q, 2'b00, cmd_code_q};
      A_STAT:  reg_rd = {req, dma_on, 4'b0000, txe, rxf};
      A_VEC:   reg_rd = vec_q;
      A_DATA:  reg_rd = rx_q;
      default: reg_rd = 8'h00;
    endcase
  end

  assign h_dout       = vec_go ? vec_q : reg_rd;
  assign h_dout_oe    = vec_go | (~h_strobe_n & h_rnw);
  assign irq_pull_low = req;
  assign tx_byte      = tx_q;
  assign cmd_pending  = cmd_q;
  assign cmd_code     = cmd_code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b1;
      rx_en      <= 1'b0;
      tx_en      <= 1'b0;
      mode       <= 2'b00;
      cmd_q      <= 1'b0;
      cmd_code_q <= 5'd0;
      vec_q      <= VEC_RESET;
      txe        <= 1'b1;
      rxf        <= 1'b0;
      rx_q       <= 8'h00;
      tx_q       <= 8'h00;
    end else begin
      strobe_q <= h_strobe_n;
      if (wr && h_addr == A_CTRL) begin
        rx_en <= h_din[0];
        tx_en <= h_din[1];
        mode  <= h_din[6:5];
      end
      if (wr && h_addr == A_VEC) vec_q <= h_din;
      if (wr && h_addr == A_CMD) cmd_code_q <= h_din[4:0];
      if (cmd_accept) cmd_q <= 1'b0;
      else if (wr && h_addr == A_CMD && h_din[7]) cmd_q <= 1'b1;
      if (wr && h_addr == A_DATA) begin
        tx_q <= h_din;
        txe  <= 1'b0;
      end else if (dsp_tx_taken) txe <= 1'b1;
      if (dsp_rx_load) begin
        rx_q <= dsp_rx_data;
        rxf  <= 1'b1;
      end else if (rd && h_addr == A_DATA) rxf <= 1'b0;
    end
  end
endmodule

// File: rtl/host_irq_unit_chk.sv
module host_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] h_addr,
  input logic       h_strobe_n,
  input logic       h_rnw,
  input logic       h_ack_n,
  input logic [7:0] h_dout,
  input logic       h_dout_oe,
  input logic       irq_pull_low,
  input logic       cmd_pending,
  input logic       cmd_accept,
  input logic [1:0] mode,
  input logic [7:0] vec_q
);
  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |-> !irq_pull_low);

  p_vector_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull_low && !h_ack_n) |-> (h_dout_oe && h_dout == vec_q));

  p_req_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_strobe_n && h_rnw && h_ack_n && h_addr == 3'd2) |-> (h_dout[7] == irq_pull_low));

  p_cmd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !cmd_pending);

  p_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pull_low && h_strobe_n) |-> !h_dout_oe);
endmodule

bind host_irq_unit host_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_strobe_n(h_strobe_n),
  .h_rnw(h_rnw), .h_ack_n(h_ack_n), .h_dout(h_dout), .h_dout_oe(h_dout_oe),
  .irq_pull_low(irq_pull_low), .cmd_pending(cmd_pending),
  .cmd_accept(cmd_accept), .mode(mode), .vec_q(vec_q)
);

// File: tb/test_host_irq_unit.sv
`timescale 1ns/1ps
module test_host_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] h_addr = 3'd0;
  logic       h_strobe_n = 1'b1;
  logic       h_rnw = 1'b1;
  logic [7:0] h_din = 8'h00;
  logic       h_ack_n = 1'b1;
  logic [7:0] h_dout;
  logic       h_dout_oe;
  logic       irq_pull_low;
  logic       dsp_tx_taken = 1'b0;
  logic       dsp_rx_load = 1'b0;
  logic [7:0] dsp_rx_data = 8'h00;
  logic [7:0] tx_byte;
  logic       cmd_pending;
  logic [4:0] cmd_code;
  logic       cmd_accept = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  host_irq_unit i_host_irq_unit (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_din = d; h_rnw = 1'b0; h_strobe_n = 1'b0;
    @(negedge clk);
    h_strobe_n = 1'b1; h_rnw = 1'b1;
    @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_rnw = 1'b1; h_strobe_n = 1'b0;
    #1 d = h_dout;
    @(negedge clk);
    h_strobe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_tx_taken();
    @(negedge clk); dsp_tx_taken = 1'b1;
    @(negedge clk); dsp_tx_taken = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] d);
    @(negedge clk); dsp_rx_load = 1'b1; dsp_rx_data = d;
    @(negedge clk); dsp_rx_load = 1'b0;
  endtask

  // {ctrl, rx_load, tx_fill, exp_req, exp_status}
  localparam int N = 8;
  localparam logic [18:0] VEC [N] = '{
    {8'h00, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h02, 1'b0, 1'b0, 1'b1, 8'h82},
    {8'h02, 1'b1, 1'b1, 1'b0, 8'h01},
    {8'h01, 1'b1, 1'b1, 1'b1, 8'h81},
    {8'h21, 1'b1, 1'b0, 1'b0, 8'h43},
    {8'h43, 1'b1, 1'b0, 1'b0, 8'h43},
    {8'h03, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h03, 1'b0, 1'b0, 1'b1, 8'h82}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq_pull_low}, 8'h00);
    hread(3'd2, d); chk("R1 status", d, 8'h02);
    hread(3'd3, d); chk("R1 vector", d, 8'h0F);
    hread(3'd0, d); chk("R1 ctrl", d, 8'h00);
    hread(3'd1, d); chk("R1 cmd", d, 8'h00);

    // R2 R5 table walk
    for (int i = 0; i < N; i++) begin
      hwrite(3'd0, VEC[i][18:11]);
      if (VEC[i][9]) hwrite(3'd6, 8'h40 + 8'(i)); else pulse_tx_taken();
      if (VEC[i][10]) pulse_rx(8'h10 + 8'(i)); else hread(3'd6, d);
      @(negedge clk);
      chk("R2 request", {7'd0, irq_pull_low}, {7'd0, VEC[i][8]});
      hread(3'd2, d); chk("R5 status", d, VEC[i][7:0]);
    end

    // R3 release on enable clear, and on data access
    hwrite(3'd0, 8'h02);
    chk("R3 pre", {7'd0, irq_pull_low}, 8'h01);
    hwrite(3'd0, 8'h00);
    chk("R3 enable clear", {7'd0, irq_pull_low}, 8'h00);
    hwrite(3'd0, 8'h02);
    hwrite(3'd6, 8'h5A);
    chk("R3 tx write release", {7'd0, irq_pull_low}, 8'h00);
    chk("R7 tx byte", tx_byte, 8'h5A);
    pulse_tx_taken();
    chk("R7 txe set", {7'd0, irq_pull_low}, 8'h01);

    // R4 vector drive
    hwrite(3'd3, 8'hA5);
    @(negedge clk);
    h_ack_n = 1'b0; h_addr = 3'd2; h_rnw = 1'b1; h_strobe_n = 1'b0;
    #1 chk("R4 vector priority", h_dout, 8'hA5);
    chk("R4 oe", {7'd0, h_dout_oe}, 8'h01);
    @(negedge clk); h_strobe_n = 1'b1; h_ack_n = 1'b1;
    hwrite(3'd0, 8'h00);
    @(negedge clk);
    h_ack_n = 1'b0;
    #1 chk("R4 no req no drive", {7'd0, h_dout_oe}, 8'h00);
    h_addr = 3'd2; h_strobe_n = 1'b0;
    #1 chk("R4 ack no req reads status", h_dout, 8'h02);
    @(negedge clk); h_strobe_n = 1'b1; h_ack_n = 1'b1;

    // R8 receive flag and R9 single access per strobe
    pulse_rx(8'h3C);
    hread(3'd2, d); chk("R8 rxf set", d, 8'h03);
    @(negedge clk);
    h_addr = 3'd6; h_rnw = 1'b1; h_strobe_n = 1'b0;
    #1 chk("R8 rx data", h_dout, 8'h3C);
    @(negedge clk); dsp_rx_load = 1'b1; dsp_rx_data = 8'h77;
    @(negedge clk); dsp_rx_load = 1'b0;
    @(negedge clk); h_strobe_n = 1'b1;
    @(negedge clk);
    hread(3'd2, d); chk("R9 held strobe no repeat", d, 8'h03);
    hread(3'd6, d); chk("R8 new data", d, 8'h77);
    hread(3'd2, d); chk("R8 rxf cleared", d, 8'h02);
    hread(3'd5, d); chk("R9 unmapped", d, 8'h00);

    // R6 command handshake
    hwrite(3'd1, 8'h85);
    chk("R6 pending", {7'd0, cmd_pending}, 8'h01);
    chk("R6 code", {3'd0, cmd_code}, 8'h05);
    hwrite(3'd1, 8'h05);
    hread(3'd1, d); chk("R6 host cannot clear", d, 8'h85);
    @(negedge clk); cmd_accept = 1'b1;
    @(negedge clk); cmd_accept = 1'b0;
    chk("R6 accept clears", {7'd0, cmd_pending}, 8'h00);
    @(negedge clk);
    h_addr = 3'd1; h_din = 8'h86; h_rnw = 1'b0; h_strobe_n = 1'b0; cmd_accept = 1'b1;
    @(negedge clk);
    cmd_accept = 1'b0; h_strobe_n = 1'b1; h_rnw = 1'b1;
    @(negedge clk);
    chk("R6 same cycle set ignored", {7'd0, cmd_pending}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule